// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block detects firmware that has stopped running. A down-counter steps once for every output tick of a prescaler that runs from the bus clock. When the counter steps below zero, the block raises a one-cycle interrupt request. The counter then reloads to all ones and carries on counting. Firmware that is alive keeps writing the start register, and each such write reloads the counter before it can run out.

The prescaler ratio depends on two things: a clock-source flag and one control bit. With the main clock source selected, the control bit chooses between divide-by-16 and divide-by-128. With the slow sub-clock source selected, the ratio is always divide-by-2. After reset both the prescaler and the counter stay idle until the first write to the start register.

Reset is the only thing that clears the prescaler. A start write or an underflow leaves the prescaler phase unchanged, so the first period after a start write can be shorter than a full period by up to one prescaler period. A hold input freezes the prescaler and the counter for as long as it is high.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, wdt_irq is low and a read of the control address (offset 0xF) returns 0x00.
- R2: Until the first write to the start address (offset 0xE), the prescaler and counter stay idle and no interrupt request is raised, whatever the source flag and hold inputs do.
- R3: A write of any data to the start address loads the counter with all ones (0x7FFF at the default 15-bit width) and enables counting from the next cycle on. The counter steps once per prescaler tick, and an underflow occurs on the tick seen while the counter holds zero.
- R4: With sub_clk_sel = 0, control bit 7 = 0 selects a prescaler ratio of 16 and bit 7 = 1 selects a ratio of 128. A new ratio applies from the next terminal count of the free-running prescaler.
- R5: With sub_clk_sel = 1, the prescaler ratio is 2 whatever the value of control bit 7.
- R6: An underflow drives wdt_irq high for exactly one cycle, in the cycle after the underflowing edge, and reloads the counter with all ones so that counting continues.
- R7: If a start write arrives in the same cycle as an underflow, the reload from the write wins and no interrupt request is raised.
- R8: While hold is high, neither the prescaler nor the counter advances.
- R9: Only reset clears the prescaler phase. Start writes and underflows leave it unchanged.
- R10: Only bit 7 of the control register can be written, and bits 6..0 always read as zero. A read of any address other than the control address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| sub_clk_sel | input | 1 | 1 when the bus clock comes from the slow sub-clock source |
| hold | input | 1 | Freezes the prescaler and the counter while high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| wdt_irq | output | 1 | One-cycle watchdog interrupt request |

## Verification
The hardest case to reach from the ports is the R7 collision, where a start write lands in exactly the cycle the counter underflows. The prescaler phase and the counter value are both hidden, so hitting that cycle by chance is unlikely. The bench keeps a cycle-exact model of the prescaler and counter, written from the requirements. It waits until that model says the next edge underflows and drives the start write into that cycle, then checks that no request follows. Random hold, source-select and start-write traffic run against the same model, which also covers R8 and R9.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    RSEL_SUB  = 2'd0,
    RSEL_LOW  = 2'd1,
    RSEL_HIGH = 2'd2
  } ratio_sel_e;

  function automatic ratio_sel_e pick_ratio(input logic sub_sel, input logic hi_bit);
    if (sub_sel)     return RSEL_SUB;
    else if (hi_bit) return RSEL_HIGH;
    else             return RSEL_LOW;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int          ADDR_W     = 4,
  parameter int          DATA_W     = 8,
  parameter int          CTRL_BIT   = 7,
  parameter logic [3:0]  START_ADDR = 4'hE,
  parameter logic [3:0]  CTRL_ADDR  = 4'hF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start_wr,
  output logic              ratio_hi
);
  localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);

  logic ctrl_q, ctrl_d;
  logic ctrl_wr;

  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_A);
  assign start_wr = bus_wr && (bus_addr == START_A);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata[CTRL_BIT];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else         ctrl_q <= ctrl_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A) bus_rdata[CTRL_BIT] = ctrl_q;
  end

  assign ratio_hi = ctrl_q;

  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rdata & ~(DATA_W'(1) << CTRL_BIT)) == '0); // R10
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr |=> (ratio_hi == $past(bus_wdata[CTRL_BIT]))); // R10
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int DIV_SUB = 2,
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic sub_sel,
  input  logic ratio_hi,
  output logic tick
);
  localparam int PSC_W = $clog2(DIV_HI);
  localparam logic [PSC_W-1:0] LIM_SUB = PSC_W'(DIV_SUB - 1);
  localparam logic [PSC_W-1:0] LIM_LO  = PSC_W'(DIV_LO - 1);
  localparam logic [PSC_W-1:0] LIM_HI  = PSC_W'(DIV_HI - 1);

  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W-1:0] limit;
  ratio_sel_e       rsel;

  assign rsel = pick_ratio(sub_sel, ratio_hi);

  always_comb begin
    case (rsel)
      RSEL_SUB:  limit = LIM_SUB;
      RSEL_HIGH: limit = LIM_HI;
      default:   limit = LIM_LO;
    endcase
  end

  // power-of-two ratios: terminal count when all selected low bits are set
  assign tick = en && ((psc_q & limit) == limit);

  always_comb begin
    psc_d = psc_q;
    if (en) psc_d = psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> $stable(psc_q)); // R8
  AST_SUB_TICK_RATE: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && sub_sel && $past(sub_sel) && $past(en) && en) |-> !$past(tick)); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start_wr,
  input  logic hold,
  input  logic tick,
  output logic psc_en,
  output logic irq
);
  localparam logic [CNT_W-1:0] RELOAD = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  logic             underflow;

  assign psc_en    = run_q && !hold;
  assign underflow = run_q && tick && (cnt_q == '0) && !start_wr;

  always_comb begin
    run_d = run_q | start_wr;
    irq_d = underflow;
    cnt_d = cnt_q;
    if (start_wr)           cnt_d = RELOAD;
    else if (run_q && tick) cnt_d = (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !start_wr) |=> ($stable(cnt_q) && !irq)); // R2
  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    start_wr |=> (cnt_q == RELOAD)); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |=> !irq); // R6
  AST_IRQ_RELOADS: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (cnt_q == RELOAD)); // R6
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    start_wr |=> !irq); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (hold && !start_wr) |=> ($stable(cnt_q) && !irq)); // R8
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int         CNT_W      = 15,
  parameter int         DIV_SUB    = 2,
  parameter int         DIV_LO     = 16,
  parameter int         DIV_HI     = 128,
  parameter logic [3:0] START_ADDR = 4'hE,
  parameter logic [3:0] CTRL_ADDR  = 4'hF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_clk_sel,
  input  logic       hold,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_irq
);
  logic rst_sync_n;
  logic start_wr;
  logic ratio_hi;
  logic psc_en;
  logic tick;

  wdt_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  wdt_regs #(
    .ADDR_W     (4),
    .DATA_W     (8),
    .CTRL_BIT   (7),
    .START_ADDR (START_ADDR),
    .CTRL_ADDR  (CTRL_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .start_wr  (start_wr),
    .ratio_hi  (ratio_hi)
  );

  wdt_prescaler #(
    .DIV_SUB (DIV_SUB),
    .DIV_LO  (DIV_LO),
    .DIV_HI  (DIV_HI)
  ) u_psc (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .en       (psc_en),
    .sub_sel  (sub_clk_sel),
    .ratio_hi (ratio_hi),
    .tick     (tick)
  );

  wdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .start_wr (start_wr),
    .hold     (hold),
    .tick     (tick),
    .psc_en   (psc_en),
    .irq      (wdt_irq)
  );

  AST_NO_IRQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> !wdt_irq); // R1
endmodule

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb;
  localparam int TB_CNT_W = 8;
  localparam logic [TB_CNT_W-1:0] TB_ONES = '1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_clk_sel = 1'b0;
  logic       hold = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdt_irq;

  int    n_vec = 0;
  int    n_bad = 0;
  int    n_irq = 0;
  int    cyc   = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  always #5 clk = ~clk;

  wdt_prescaled #(.CNT_W(TB_CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sub_clk_sel(sub_clk_sel), .hold(hold),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_irq(wdt_irq)
  );

  // reference model built from the requirements
  logic                m_s1, m_s2, m_run, m_ctrl, m_irq;
  logic [6:0]          m_psc;
  logic [TB_CNT_W-1:0] m_cnt;

  function automatic logic [6:0] ratio_lim(input logic sub, input logic hi);
    if (sub) return 7'd1;
    return hi ? 7'd127 : 7'd15;
  endfunction

  function automatic logic will_underflow(input logic hld);
    logic [6:0] l;
    l = ratio_lim(sub_clk_sel, m_ctrl);
    return m_run && !hld && ((m_psc & l) == l) && (m_cnt == '0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_ctrl <= 0; m_irq <= 0;
      m_psc <= '0; m_cnt <= '0;
    end else begin
      m_s1 <= 1'b1;
      m_s2 <= m_s1;
      if (m_s2) begin : upd
        logic en, tk, st;
        logic [6:0] l;
        l  = ratio_lim(sub_clk_sel, m_ctrl);
        en = m_run && !hold;
        tk = en && ((m_psc & l) == l);
        st = bus_wr && (bus_addr == 4'hE);
        if (en) m_psc <= m_psc + 7'd1;
        m_irq <= m_run && tk && (m_cnt == '0) && !st;
        if (st) m_cnt <= TB_ONES;
        else if (m_run && tk) m_cnt <= (m_cnt == '0) ? TB_ONES : m_cnt - 1'b1;
        if (st) m_run <= 1'b1;
        if (bus_wr && bus_addr == 4'hF) m_ctrl <= bus_wdata[7];
      end
    end
  end

  // per-cycle compare of the request line, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (wdt_irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq: actual %0b expected %0b at cycle %0d", tag, wdt_irq, m_irq, cyc);
      end
      if (wdt_irq) n_irq++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected end before 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [7:0] exp, input string r);
    bus_addr = a;
    #1;
    n_vec++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read 0x%0h: actual 0x%02h expected 0x%02h", r, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_true(input bit c, input string r, input int act, input int exp);
    n_vec++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  initial begin
    int seen;
    void'($urandom(32'd2024));
    tick_n(3);
    rst_n = 1'b1;
    tick_n(4);
    // R1 reset state
    chk_true(wdt_irq == 1'b0, "R1 irq after reset", wdt_irq, 0);
    chk_rd(4'hF, 8'h00, "R1");

    // R2 idle without a start write, random select and hold
    tag = "R2";
    for (int i = 0; i < 2000; i++) begin
      sub_clk_sel = 1'($urandom);
      hold        = ($urandom % 4) == 0;
      @(negedge clk);
    end
    hold = 1'b0;
    chk_true(n_irq == 0, "R2 no irq before start", n_irq, 0);

    // R10 control register field
    tag = "R10";
    wr(4'hF, 8'hFF);  chk_rd(4'hF, 8'h80, "R10");
    wr(4'hF, 8'h7F);  chk_rd(4'hF, 8'h00, "R10");
    wr(4'hF, 8'h80);  chk_rd(4'hF, 8'h80, "R10");
    chk_rd(4'hE, 8'h00, "R10");
    chk_rd(4'h3, 8'h00, "R10");

    // R5 sub-clock ratio with control bit 7 set
    tag = "R5"; sub_clk_sel = 1'b1;
    seen = n_irq;
    wr(4'hE, 8'h5A);
    tick_n(1600);
    chk_true(n_irq - seen >= 2, "R5 irqs at ratio 2", n_irq - seen, 3);

    // R4 ratio 16
    tag = "R4"; sub_clk_sel = 1'b0;
    wr(4'hF, 8'h00);
    seen = n_irq;
    wr(4'hE, 8'h00);
    tick_n(9000);
    chk_true(n_irq - seen >= 2, "R4 irqs at ratio 16", n_irq - seen, 2);

    // R9 restart mid prescaler period keeps phase
    tag = "R9";
    for (int i = 0; i < 6; i++) begin
      tick_n(5 + ($urandom % 40));
      wr(4'hE, 8'($urandom));
    end
    tick_n(4200);

    // R4 ratio 128
    tag = "R4";
    wr(4'hF, 8'h80);
    seen = n_irq;
    wr(4'hE, 8'h01);
    tick_n(66000);
    chk_true(n_irq - seen >= 1, "R4 irqs at ratio 128", n_irq - seen, 2);

    // R8 random hold with sub-clock, rare random restarts
    tag = "R8"; sub_clk_sel = 1'b1;
    wr(4'hE, 8'h00);
    for (int i = 0; i < 6000; i++) begin
      hold = ($urandom % 3) == 0;
      if (($urandom % 500) == 0) begin
        bus_addr = 4'hE; bus_wr = 1'b1;
      end
      @(negedge clk);
      bus_wr = 1'b0;
    end
    hold = 1'b0;

    // R6 plain periodic requests
    tag = "R6";
    seen = n_irq;
    tick_n(1100);
    chk_true(n_irq - seen == 2, "R6 one-cycle pulses per period", n_irq - seen, 2);

    // R7 start write in the underflow cycle
    tag = "R7";
    for (int k = 0; k < 3; k++) begin
      while (!will_underflow(1'b0)) @(negedge clk);
      bus_addr = 4'hE; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk_true(wdt_irq == 1'b0, "R7 no irq on colliding start", wdt_irq, 0);
    end
    tick_n(20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule